// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor that finishes every instruction in one clock period. It supports eight instructions: word load, word store, branch-if-equal, and five register-to-register operations (add, subtract, AND, OR and signed set-less-than). The block holds its program counter, a small instruction ROM, a data RAM, a 32-entry register file, the sign extender, the ALU and a control unit. The control unit decodes in two levels. The opcode yields a 2-bit ALU class. That class, together with the function field, then yields a 3-bit ALU operation code.

The ROM and the RAM have no external bus. A test preload port writes one word per clock into either array. This is how a program and its constant data are placed before reset is released. Debug outputs show the current program counter and the register write that commits at the next rising edge, so the core can be observed one instruction at a time.

Top module: `sc_cpu_top`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and every register is cleared. While `rst` is high, `dbg_wb_en` stays low and no memory write takes place.
- R2: Instruction fields sit at fixed bit positions: opcode [31:26], first source [25:21], second source or load target [20:16], R-type destination [15:11] and function [5:0]. The I-type immediate is [15:0]. It is sign-extended wherever it is used.
- R3: Opcode 000000 selects a register operation chosen by the function field: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 set-less-than. Set-less-than gives 1 when the first source is below the second as a signed number, and 0 otherwise. The result is written to the destination at [15:11].
- R4: Opcode 100011 loads the data word at address (first source + sign-extended immediate) into the register at [20:16]. Words are indexed by address bits from bit 2 upward.
- R5: Opcode 101011 stores the register at [20:16] to the word at (first source + sign-extended immediate) and writes no register.
- R6: Opcode 000100 compares its two sources. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by two. When they differ, the next PC is PC+4. No register is written.
- R7: Register 0 always reads as zero, and any write to it is dropped.
- R8: Any other opcode writes no register, writes no memory and advances the PC by 4.
- R9: When `pre_we` is high at a rising edge, `pre_data` is written at word `pre_addr` of the instruction ROM (`pre_dmem`=0) or of the data RAM (`pre_dmem`=1).
- R10: Every instruction other than a taken branch advances the PC by exactly 4. `dbg_wb_en`, `dbg_wb_addr` and `dbg_wb_data` show the register write of the current instruction in the same cycle that it commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | Preload write strobe |
| pre_dmem | input | 1 | Preload target: 0 instruction ROM, 1 data RAM |
| pre_addr | input | PRE_AW (6) | Preload word index |
| pre_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Current program counter |
| dbg_wb_en | output | 1 | Register write occurs at the next edge |
| dbg_wb_addr | output | 5 | Destination register of that write |
| dbg_wb_data | output | 32 | Value written |

## Verification
The main test runs a doubling loop that grows a value from 1 to 128 and counts the passes. The loop's branch falls through seven times and is taken once, so both outcomes of the branch test show up in the PC trace. A straight-line tail then exercises each register operation. Set-less-than gets a negative operand, which separates signed from unsigned comparison. A store is followed by a load of the same word, a load uses a negative offset, and an undefined opcode and a write to register 0 are each followed by an instruction whose result shows whether that earlier instruction had any effect. A second reset in mid-run checks that execution restarts cleanly from address zero.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10
  } alu_class_e;

  typedef enum logic [2:0] {
    AOP_AND = 3'b000,
    AOP_OR  = 3'b001,
    AOP_ADD = 3'b010,
    AOP_SUB = 3'b110,
    AOP_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic       reg_we;
    logic       dst_rd;
    logic       src_imm;
    alu_class_e cls;
    logic       is_branch;
    logic       mem_we;
    logic       wb_mem;
  } ctl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] seq_pc(input logic [XLEN-1:0] pc);
    return pc + 32'd4;
  endfunction

  function automatic logic [XLEN-1:0] jump_pc(input logic [XLEN-1:0] pc,
                                              input logic [15:0] off);
    return seq_pc(pc) + {sext16(off)[XLEN-3:0], 2'b00};
  endfunction

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_cpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl,
  output alu_op_e    aop
);

  always_comb begin
    ctl = '0;
    unique case (opcode)
      OP_REG: begin
        ctl.reg_we = 1'b1;
        ctl.dst_rd = 1'b1;
        ctl.cls    = CLS_FUNC;
      end
      OP_LOAD: begin
        ctl.reg_we  = 1'b1;
        ctl.src_imm = 1'b1;
        ctl.cls     = CLS_ADD;
        ctl.wb_mem  = 1'b1;
      end
      OP_STORE: begin
        ctl.src_imm = 1'b1;
        ctl.cls     = CLS_ADD;
        ctl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctl.cls       = CLS_SUB;
        ctl.is_branch = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  always_comb begin
    aop = AOP_ADD;
    case (ctl.cls)
      CLS_ADD: aop = AOP_ADD;
      CLS_SUB: aop = AOP_SUB;
      default: begin
        case (funct)
          FN_ADD:  aop = AOP_ADD;
          FN_SUB:  aop = AOP_SUB;
          FN_AND:  aop = AOP_AND;
          FN_OR:   aop = AOP_OR;
          FN_SLT:  aop = AOP_SLT;
          default: aop = AOP_ADD;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_cpu_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  always_comb begin
    case (op)
      AOP_ADD: y = a + b;
      AOP_SUB: y = a - b;
      AOP_AND: y = a & b;
      AOP_OR:  y = a | b;
      AOP_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_cpu_pkg::*;
#(
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd
);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_cpu_top.sv
module sc_cpu_top
  import sc_cpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W   = $clog2(IMEM_WORDS),
  localparam int DA_W   = $clog2(DMEM_WORDS),
  localparam int PRE_AW = (IA_W > DA_W) ? IA_W : DA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_we,
  input  logic              pre_dmem,
  input  logic [PRE_AW-1:0] pre_addr,
  input  logic [31:0]       pre_data,
  output logic [31:0]       dbg_pc,
  output logic              dbg_wb_en,
  output logic [4:0]        dbg_wb_addr,
  output logic [31:0]       dbg_wb_data
);

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] pc_next;
  logic [XLEN-1:0] instr;
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [5:0]      f_op, f_fn;
  logic [RIDX-1:0] f_rs, f_rt, f_rd;
  logic [15:0]     f_imm;

  ctl_t            ctl;
  alu_op_e         aop;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, ld_val, wb_val;
  logic            alu_zero;
  logic [RIDX-1:0] dst;

  // events brought out for the checker
  logic            br_taken;
  logic            mem_we;
  logic            reg_commit;

  // instruction fetch
  assign instr = imem[pc[IA_W+1:2]];

  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];

  sc_ctrl u_ctrl (
    .opcode (f_op),
    .funct  (f_fn),
    .ctl    (ctl),
    .aop    (aop)
  );

  sc_regfile #(.NREG(32)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (f_rs),
    .ra2 (f_rt),
    .rd1 (rs_val),
    .rd2 (rt_val),
    .we  (reg_commit),
    .wa  (dst),
    .wd  (wb_val)
  );

  assign imm_ext = sext16(f_imm);
  assign alu_b   = ctl.src_imm ? imm_ext : rt_val;

  sc_alu u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (aop),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign ld_val     = dmem[alu_y[DA_W+1:2]];
  assign wb_val     = ctl.wb_mem ? ld_val : alu_y;
  assign dst        = ctl.dst_rd ? f_rd : f_rt;
  assign reg_commit = ctl.reg_we & ~rst;
  assign mem_we     = ctl.mem_we & ~rst;
  assign br_taken   = ctl.is_branch & alu_zero & ~rst;

  assign pc_next = br_taken ? jump_pc(pc, f_imm) : seq_pc(pc);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (pre_we && !pre_dmem) imem[pre_addr[IA_W-1:0]] <= pre_data;
  end

  always_ff @(posedge clk) begin
    if (pre_we && pre_dmem)  dmem[pre_addr[DA_W-1:0]] <= pre_data;
    else if (mem_we)         dmem[alu_y[DA_W+1:2]] <= rt_val;
  end

  assign dbg_pc      = pc;
  assign dbg_wb_en   = reg_commit;
  assign dbg_wb_addr = dst;
  assign dbg_wb_data = wb_val;

  logic unused_bits;
  assign unused_bits = ^{pc[1:0], pc[XLEN-1:IA_W+2], alu_y[1:0], alu_y[XLEN-1:DA_W+2],
                         instr[10:6], pre_addr};

endmodule

// File: rtl/sc_cpu_chk.sv
module sc_cpu_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] dbg_pc,
  input logic [31:0] instr,
  input logic        dbg_wb_en,
  input logic [4:0]  dbg_wb_addr,
  input logic        mem_we,
  input logic        br_taken
);

  logic [5:0] opc;
  logic       known;
  logic       rst_seen = 1'b0;

  assign opc   = instr[31:26];
  assign known = (opc == 6'b000000) || (opc == 6'b100011) ||
                 (opc == 6'b101011) || (opc == 6'b000100);

  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst && rst_seen) begin
      AST_RESET_STATE: assert (dbg_pc == 32'd0 && !dbg_wb_en && !mem_we); // R1
    end
  end

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    !br_taken |=> (dbg_pc == $past(dbg_pc) + 32'd4)); // R10

  AST_BR_TARGET: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (dbg_pc == $past(dbg_pc) + 32'd4 +
                  {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00})); // R6

  AST_BR_ONLY_BEQ: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (opc == 6'b000100 && !dbg_wb_en)); // R6

  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!dbg_wb_en && !mem_we && !br_taken)); // R8

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (!dbg_wb_en && opc == 6'b101011)); // R5

  AST_REG_DEST: assert property (@(posedge clk) disable iff (rst)
    (dbg_wb_en && opc == 6'b000000) |-> (dbg_wb_addr == instr[15:11])); // R3

  AST_LOAD_DEST: assert property (@(posedge clk) disable iff (rst)
    (dbg_wb_en && opc == 6'b100011) |-> (dbg_wb_addr == instr[20:16])); // R4

endmodule

bind sc_cpu_top sc_cpu_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .dbg_pc      (dbg_pc),
  .instr       (instr),
  .dbg_wb_en   (dbg_wb_en),
  .dbg_wb_addr (dbg_wb_addr),
  .mem_we      (mem_we),
  .br_taken    (br_taken)
);

// File: tb/sim_sc_cpu_top.sv
module sim_sc_cpu_top;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_we = 1'b0;
  logic        pre_dmem = 1'b0;
  logic [5:0]  pre_addr = '0;
  logic [31:0] pre_data = '0;
  logic [31:0] dbg_pc;
  logic        dbg_wb_en;
  logic [4:0]  dbg_wb_addr;
  logic [31:0] dbg_wb_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  sc_cpu_top u0 (
    .clk(clk), .rst(rst), .pre_we(pre_we), .pre_dmem(pre_dmem),
    .pre_addr(pre_addr), .pre_data(pre_data), .dbg_pc(dbg_pc),
    .dbg_wb_en(dbg_wb_en), .dbg_wb_addr(dbg_wb_addr), .dbg_wb_data(dbg_wb_data)
  );

  // behavioural reference state
  logic [31:0] m_rom [64];
  logic [31:0] m_ram [64];
  logic [31:0] m_reg [32];
  logic [31:0] m_pc;
  logic [31:0] seen [32];   // last value the core reported for each register

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic preload(input bit to_ram, input int idx, input logic [31:0] w);
    @(negedge clk);
    pre_we = 1'b1; pre_dmem = to_ram; pre_addr = idx[5:0]; pre_data = w;
    if (to_ram) m_ram[idx] = w; else m_rom[idx] = w;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic model_reset();
    m_pc = 0;
    for (int i = 0; i < 32; i++) m_reg[i] = 0;
  endtask

  // compare outputs with the model for the current instruction, then advance the model
  task automatic step_and_compare();
    logic [31:0] ins, a, b, simm, addr, res, npc;
    logic [5:0]  op;
    bit          we;
    int          wa;
    string       tag;
    ins  = m_rom[m_pc[7:2]];
    op   = ins[31:26];
    a    = m_reg[ins[25:21]];
    b    = m_reg[ins[20:16]];
    simm = {{16{ins[15]}}, ins[15:0]};
    npc  = m_pc + 4;
    we = 0; wa = 0; res = 0; tag = "R8";
    if (op == 6'b000000) begin
      tag = "R3"; we = 1; wa = ins[15:11];
      case (ins[5:0])
        6'b100000: res = a + b;
        6'b100010: res = a - b;
        6'b100100: res = a & b;
        6'b100101: res = a | b;
        6'b101010: res = ($signed(a) < $signed(b)) ? 1 : 0;
        default:   res = a + b;
      endcase
    end else if (op == 6'b100011) begin
      tag = "R4"; we = 1; wa = ins[20:16];
      addr = a + simm; res = m_ram[addr[7:2]];
    end else if (op == 6'b101011) begin
      tag = "R5"; addr = a + simm; m_ram[addr[7:2]] = b;
    end else if (op == 6'b000100) begin
      tag = "R6";
      if (a == b) npc = m_pc + 4 + (simm << 2);
    end
    chk(dbg_pc == m_pc, "R10", "pc", dbg_pc, m_pc);
    chk(dbg_wb_en == we, tag, "wb_en", {31'd0, dbg_wb_en}, {31'd0, we});
    if (we) begin
      chk(dbg_wb_addr == wa[4:0], "R2", "wb_addr", {27'd0, dbg_wb_addr}, wa);
      chk(dbg_wb_data == res, tag, "wb_data", dbg_wb_data, res);
    end
    if (dbg_wb_en && dbg_wb_addr != 0) seen[dbg_wb_addr] = dbg_wb_data;
    if (we && wa != 0) m_reg[wa] = res;
    m_pc = npc;
  endtask

  initial begin
    #(CLK_NS * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_rom[i] = 0; m_ram[i] = 0; end
    for (int i = 0; i < 32; i++) seen[i] = 0;
    model_reset();

    // R9: preload constants into data RAM and the program into ROM
    preload(1, 0, 32'd1);
    preload(1, 1, 32'd128);
    preload(1, 3, 32'd12);
    preload(0, 0,  enc_i(6'b100011, 0, 16, 0));      // lw  r16, 0(r0)
    preload(0, 1,  enc_i(6'b100011, 0, 9, 0));       // lw  r9, 0(r0)
    preload(0, 2,  enc_i(6'b100011, 0, 8, 4));       // lw  r8, 4(r0)
    preload(0, 3,  enc_r(0, 0, 17, 6'b100000));      // add r17, r0, r0
    preload(0, 4,  enc_i(6'b000100, 16, 8, 3));      // beq r16, r8, +3
    preload(0, 5,  enc_r(16, 16, 16, 6'b100000));    // add r16, r16, r16
    preload(0, 6,  enc_r(17, 9, 17, 6'b100000));     // add r17, r17, r9
    preload(0, 7,  enc_i(6'b000100, 0, 0, -4));      // beq r0, r0, -4
    preload(0, 8,  enc_i(6'b101011, 0, 17, 8));      // sw  r17, 8(r0)
    preload(0, 9,  enc_i(6'b100011, 0, 10, 8));      // lw  r10, 8(r0)
    preload(0, 10, enc_r(8, 16, 11, 6'b100010));     // sub r11, r8, r16
    preload(0, 11, enc_r(17, 9, 12, 6'b100100));     // and r12, r17, r9
    preload(0, 12, enc_r(16, 17, 13, 6'b100101));    // or  r13, r16, r17
    preload(0, 13, enc_r(17, 8, 14, 6'b101010));     // slt r14, r17, r8
    preload(0, 14, enc_r(8, 17, 15, 6'b101010));     // slt r15, r8, r17
    preload(0, 15, 32'hFC00_0000);                   // undefined opcode
    preload(0, 16, enc_r(9, 9, 0, 6'b100000));       // add r0, r9, r9
    preload(0, 17, enc_r(0, 9, 18, 6'b100000));      // add r18, r0, r9
    preload(0, 18, enc_r(0, 9, 19, 6'b100010));      // sub r19, r0, r9
    preload(0, 19, enc_r(19, 0, 20, 6'b101010));     // slt r20, r19, r0
    preload(0, 20, enc_i(6'b100011, 0, 24, 12));     // lw  r24, 12(r0)
    preload(0, 21, enc_i(6'b100011, 24, 21, -4));    // lw  r21, -4(r24)
    preload(0, 22, enc_i(6'b000100, 0, 0, -1));      // beq r0, r0, -1 (hold)

    @(negedge clk);
    chk(dbg_pc == 0, "R1", "reset pc", dbg_pc, 0);
    chk(!dbg_wb_en, "R1", "reset wb_en", {31'd0, dbg_wb_en}, 0);

    rst = 1'b0;
    #1;
    for (int c = 0; c < 60; c++) begin
      step_and_compare();
      @(negedge clk);
      #1;
    end

    chk(seen[9]  == 1,   "R9", "r9 from preloaded RAM", seen[9], 1);
    chk(seen[16] == 128, "R6", "loop value r16", seen[16], 128);
    chk(seen[17] == 7,   "R6", "loop count r17", seen[17], 7);
    chk(seen[10] == 7,   "R5", "stored then loaded r10", seen[10], 7);
    chk(seen[11] == 0,   "R3", "sub r11", seen[11], 0);
    chk(seen[12] == 1,   "R3", "and r12", seen[12], 1);
    chk(seen[13] == 135, "R3", "or r13", seen[13], 135);
    chk(seen[14] == 1,   "R3", "slt true r14", seen[14], 1);
    chk(seen[15] == 0,   "R3", "slt false r15", seen[15], 0);
    chk(seen[18] == 1,   "R7", "r0 still zero r18", seen[18], 1);
    chk(seen[20] == 1,   "R3", "signed slt r20", seen[20], 1);
    chk(seen[21] == 7,   "R4", "negative offset load r21", seen[21], 7);
    chk(dbg_pc == 88,    "R6", "halt loop pc", dbg_pc, 88);
    chk(seen[19] == 32'hFFFF_FFFF, "R8", "undefined opcode left r19 path", seen[19], 32'hFFFF_FFFF);

    // second reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(dbg_pc == 0, "R1", "re-reset pc", dbg_pc, 0);
    chk(!dbg_wb_en, "R1", "re-reset wb_en", {31'd0, dbg_wb_en}, 0);
    model_reset();
    rst = 1'b0;
    #1;
    for (int c = 0; c < 12; c++) begin
      step_and_compare();
      @(negedge clk);
      #1;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule